// File: doc/BRIEF.md
# Wake-up Interrupt Controller

This block lets a processor sleep in a clock-stopped state without waking up at intervals to poll its interrupts. When the power controller signals entry into a low-power state, the block stores a qualification vector from the interrupt controller. A set bit in that vector marks a line that is both enabled and of high enough priority to be serviced at once. From then on the stored vector, and not the live one, decides which raw interrupt lines may end the sleep.

While the clocks are reported stopped, any qualified line that goes active is caught in a sticky per-line latch. Once a line is caught, the block raises a wake request to the power controller. The request stays high until the power controller acknowledges that clocks run again. Alongside the request, the block reports the number of the lowest caught line. Arbitration between interrupts after wake-up is left to the interrupt controller.

Top module: `wake_irq_ctrl`

## Requirements
- R1: After reset, `wake_req` is 0 and `wake_idx` is 0. Interrupt activity or `clk_ack` seen before any sleep entry never raises `wake_req`.
- R2: The qualification vector `wake_mask` is stored on the cycle `sleep_enter` is sampled high. Changes to `wake_mask` after that cycle have no effect until the next entry.
- R3: Suppose `clk_stopped` is 1 and a line whose stored mask bit is 1 is sampled high after entry. Then `wake_req` is 1 from the next cycle on.
- R4: A line whose stored mask bit is 0 never raises `wake_req`, whatever its level.
- R5: Suppose a line with its `wake_mask` bit set is already high in the entry cycle. Then `wake_req` is 1 on the cycle after entry, even if `clk_stopped` is still 0.
- R6: A qualifying line that is active for only one cycle keeps `wake_req` high after the line returns low.
- R7: `wake_req` stays high until `clk_ack` is sampled high, then falls on the next cycle. After that, lines cannot raise `wake_req` until the next entry.
- R8: While `wake_req` is 1, `wake_idx` is the binary number of the lowest-numbered caught line, counting bit 0 as line 0. While `wake_req` is 0, `wake_idx` is 0.
- R9: A sleep entry discards every previously caught line. If `sleep_enter` and `clk_ack` are sampled in the same cycle, the entry wins and the block stays armed with the new mask.
- R10: After entry, activity on a qualified line while `clk_stopped` is 0 is not caught.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock of the wake logic |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_raw | input | NUM_LINES | Raw interrupt lines, active high |
| wake_mask | input | NUM_LINES | Enabled-and-priority qualification from the interrupt controller |
| sleep_enter | input | 1 | One-cycle strobe marking entry into a clock-stopped mode |
| clk_stopped | input | 1 | High while the core clocks are stopped |
| clk_ack | input | 1 | Power controller acknowledge that clocks are running |
| wake_req | output | 1 | Wake request to the power controller |
| wake_idx | output | IDX_W | Lowest-numbered caught line |

## Verification
Two functions can fall in the same cycle. The first pair is a sleep entry and a line that is already active: the entry latches the line itself and must raise the request on the very next cycle. The second pair is a sleep entry and the acknowledge of an earlier wake: the entry must win, clear the stale caught lines and keep the block armed. The bench provokes both by driving the two inputs in one cycle. It judges the result one cycle later from `wake_req` and `wake_idx`, and then shows that a fresh line under the new mask still wakes the block with the correct index.

// File: rtl/wake_irq_pkg.sv
// Package: shared constants for the wake-up interrupt controller.
// Assumes: consumers derive their index width with idx_width().
package wake_irq_pkg;

    // Default number of interrupt lines watched while asleep
    localparam int unsigned DEF_LINES = 32;

    // Width of a line index; at least one bit even for a single line
    function automatic int unsigned idx_width(input int unsigned lines);
        return (lines > 1) ? $clog2(lines) : 1;
    endfunction

endpackage

// File: rtl/wake_arm_ctrl.sv
// Module: wake_arm_ctrl
// Stores the qualification mask at sleep entry and tracks the armed
// window, which runs from entry until the clocks are acknowledged.
// Assumes: sleep_enter is a strobe; entry takes precedence over ack.
module wake_arm_ctrl #(
    parameter int unsigned NUM_LINES = wake_irq_pkg::DEF_LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] wake_mask,
    input  logic                 sleep_enter,
    input  logic                 clk_ack,
    output logic [NUM_LINES-1:0] mask_q,
    output logic                 armed_q
);

    // Store the qualification vector only at entry
    always_ff @(posedge clk) begin
        if (!rst_n)           mask_q <= '0;
        else if (sleep_enter) mask_q <= wake_mask;
    end

    // Arm at entry, disarm on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)           armed_q <= 1'b0;
        else if (sleep_enter) armed_q <= 1'b1;
        else if (clk_ack)     armed_q <= 1'b0;
    end

    // R7
    disarm_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ack && !sleep_enter) |=> !armed_q);

    // R9
    entry_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_enter |=> (armed_q && mask_q == $past(wake_mask)));

endmodule

// File: rtl/wake_pend_latch.sv
// Module: wake_pend_latch
// One sticky bit per line. A bit is set by a qualified active line and
// is cleared only by the next sleep entry. At entry, the lines that are
// already active and qualified by the incoming mask are loaded at once.
// Assumes: mask_q and armed_q come from wake_arm_ctrl.
module wake_pend_latch #(
    parameter int unsigned NUM_LINES = wake_irq_pkg::DEF_LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_raw,
    input  logic [NUM_LINES-1:0] wake_mask,
    input  logic [NUM_LINES-1:0] mask_q,
    input  logic                 sleep_enter,
    input  logic                 armed_q,
    input  logic                 clk_stopped,
    output logic [NUM_LINES-1:0] pend_q
);

    logic watch;
    // Detection window: armed and clocks reported stopped
    always_comb watch = armed_q && clk_stopped;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Per-line sticky capture
        always_ff @(posedge clk) begin
            if (!rst_n)                          pend_q[g] <= 1'b0;
            else if (sleep_enter)                pend_q[g] <= irq_raw[g] & wake_mask[g];
            else if (watch && irq_raw[g] && mask_q[g]) pend_q[g] <= 1'b1;
        end
    end

    // R4
    only_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~mask_q) == '0);

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_enter |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/wake_low_enc.sv
// Module: wake_low_enc
// Finds the lowest set bit of a vector and returns its index.
// Assumes: index is 0 when no bit is set; 'any' flags a set bit.
module wake_low_enc #(
    parameter int unsigned NUM_LINES = wake_irq_pkg::DEF_LINES,
    localparam int unsigned IDX_W    = wake_irq_pkg::idx_width(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] vec,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);

    // Scan downward so the lowest set bit is the last one written
    always_comb begin
        idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
        any = |vec;
    end

endmodule

// File: rtl/wake_irq_ctrl.sv
// Module: wake_irq_ctrl (top)
// Wakes the core from clock-stopped modes. It catches qualified lines
// while asleep and holds the wake request until clocks are acknowledged.
// Assumes: clk is an always-on clock; reset is synchronous, active low.
module wake_irq_ctrl #(
    parameter int unsigned NUM_LINES = wake_irq_pkg::DEF_LINES,
    localparam int unsigned IDX_W    = wake_irq_pkg::idx_width(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_raw,
    input  logic [NUM_LINES-1:0] wake_mask,
    input  logic                 sleep_enter,
    input  logic                 clk_stopped,
    input  logic                 clk_ack,
    output logic                 wake_req,
    output logic [IDX_W-1:0]     wake_idx
);

    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] pend_q;
    logic                 armed_q;
    logic                 pend_any;
    logic [IDX_W-1:0]     low_idx;

    wake_arm_ctrl #(.NUM_LINES(NUM_LINES)) u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_mask   (wake_mask),
        .sleep_enter (sleep_enter),
        .clk_ack     (clk_ack),
        .mask_q      (mask_q),
        .armed_q     (armed_q)
    );

    wake_pend_latch #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_raw     (irq_raw),
        .wake_mask   (wake_mask),
        .mask_q      (mask_q),
        .sleep_enter (sleep_enter),
        .armed_q     (armed_q),
        .clk_stopped (clk_stopped),
        .pend_q      (pend_q)
    );

    wake_low_enc #(.NUM_LINES(NUM_LINES)) u_enc (
        .vec (pend_q),
        .any (pend_any),
        .idx (low_idx)
    );

    // Request while armed with a caught line; index only while requesting
    always_comb begin
        wake_req = armed_q && pend_any;
        wake_idx = wake_req ? low_idx : '0;
    end

    // R7
    ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && clk_ack && !sleep_enter) |=> !wake_req);

    // R8
    idx_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> pend_q[wake_idx]);

    // R8
    idx_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ((pend_q & ((NUM_LINES'(1) << wake_idx) - NUM_LINES'(1))) == '0));

endmodule

// File: tb/tb_wake_irq_ctrl.sv
module tb_wake_irq_ctrl;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_raw = '0;
    logic [N-1:0] wake_mask = '0;
    logic         sleep_enter = 1'b0;
    logic         clk_stopped = 1'b0;
    logic         clk_ack = 1'b0;
    logic         wake_req;
    logic [2:0]   wake_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wake_irq_ctrl #(.NUM_LINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .wake_mask(wake_mask),
        .sleep_enter(sleep_enter), .clk_stopped(clk_stopped),
        .clk_ack(clk_ack), .wake_req(wake_req), .wake_idx(wake_idx)
    );

    typedef struct packed {
        logic [7:0] m;    // mask at entry
        logic [7:0] e;    // lines active in entry cycle
        logic [7:0] p;    // one-cycle pulse while asleep
        logic       w;    // expected wake
        logic [2:0] ix;   // expected index
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h0F, 8'h00, 8'h04, 1'b1, 3'd2},
        '{8'h0F, 8'h00, 8'hF0, 1'b0, 3'd0},
        '{8'hA0, 8'h00, 8'hFF, 1'b1, 3'd5},
        '{8'h81, 8'h80, 8'h01, 1'b1, 3'd0},
        '{8'h00, 8'hFF, 8'hFF, 1'b0, 3'd0},
        '{8'hFF, 8'h40, 8'h00, 1'b1, 3'd6},
        '{8'h30, 8'h10, 8'h20, 1'b1, 3'd4},
        '{8'h80, 8'h00, 8'h80, 1'b1, 3'd7}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("R1 reset wake_req", int'(wake_req), 0);
        check("R1 reset wake_idx", int'(wake_idx), 0);

        // R1: activity and ack with no entry
        irq_raw = 8'hFF; wake_mask = 8'hFF; clk_stopped = 1'b1; clk_ack = 1'b1;
        tick(); tick();
        check("R1 no entry no wake", int'(wake_req), 0);
        irq_raw = '0; clk_ack = 1'b0; clk_stopped = 1'b0;
        tick();

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        foreach (VECS[k]) begin
            sleep_enter = 1'b1; wake_mask = VECS[k].m; irq_raw = VECS[k].e;
            tick();
            sleep_enter = 1'b0; wake_mask = ~VECS[k].m; irq_raw = '0;
            clk_stopped = 1'b1;
            check($sformatf("R5 entry-active v%0d", k), int'(wake_req),
                  int'((VECS[k].e & VECS[k].m) != 0));
            irq_raw = VECS[k].p;
            tick();
            irq_raw = '0;
            tick();
            check($sformatf("R3/R4/R6 wake v%0d", k), int'(wake_req), int'(VECS[k].w));
            check($sformatf("R8 idx v%0d", k), int'(wake_idx), int'(VECS[k].ix));
            tick();
            check($sformatf("R7 hold v%0d", k), int'(wake_req), int'(VECS[k].w));
            clk_ack = 1'b1; clk_stopped = 1'b0;
            tick();
            clk_ack = 1'b0;
            check($sformatf("R7 drop v%0d", k), int'(wake_req), 0);
            check($sformatf("R8 idx idle v%0d", k), int'(wake_idx), 0);
        end

        // R7: after ack, lines do not wake until next entry
        irq_raw = 8'hFF; wake_mask = 8'hFF; clk_stopped = 1'b1;
        tick(); tick();
        check("R7 disarmed after ack", int'(wake_req), 0);
        irq_raw = '0; clk_stopped = 1'b0;

        // R10: activity before clocks stop is not caught
        sleep_enter = 1'b1; wake_mask = 8'h02;
        tick();
        sleep_enter = 1'b0; irq_raw = 8'h02;
        tick();
        irq_raw = '0; clk_stopped = 1'b1;
        tick();
        check("R10 clocks running ignored", int'(wake_req), 0);
        irq_raw = 8'h02;
        tick();
        irq_raw = '0;
        check("R10 then stopped wakes", int'(wake_req), 1);
        check("R10 idx", int'(wake_idx), 1);

        // R9: entry together with ack, stale line discarded
        sleep_enter = 1'b1; clk_ack = 1'b1; wake_mask = 8'h08; clk_stopped = 1'b0;
        tick();
        sleep_enter = 1'b0; clk_ack = 1'b0; clk_stopped = 1'b1;
        check("R9 stale cleared", int'(wake_req), 0);
        irq_raw = 8'h0A;
        tick();
        irq_raw = '0;
        check("R9 still armed", int'(wake_req), 1);
        check("R9 new mask idx", int'(wake_idx), 3);
        clk_ack = 1'b1; clk_stopped = 1'b0;
        tick();
        clk_ack = 1'b0;
        check("R9 final drop", int'(wake_req), 0);

        finish_run();
    end

endmodule